// File: doc/BRIEF.md
# Splittable Dual-Half Interval Timer

This block is a general timer built from two 16-bit counting halves, A and B. A configuration field joins the halves into a single 32-bit down-counter, joins them into a 32-bit up-counter advanced by rising edges on an external tick pin, or splits them into two independent 16-bit down-counters. In split operation each half has its own 8-bit clock prescaler, load value, match value, enable and one-shot/periodic mode.

Software programs the timer through a one-cycle write port. Reaching zero raises a timeout flag and matching the match value raises a match flag. The flags are sticky until software writes a 1 to the matching clear bit. A mask selects which flags drive the single interrupt line. The counter values, the enable bits and the flag, mask and status vectors are visible on output ports.

Top module: `split_timer`

## Requirements
- R1: Reset leaves both counts at 0xFFFF, both load values at 0xFFFF, both match values at 0, both prescale values and prescale counters at 0, the configuration at 0, enables and modes cleared, and flags, mask and interrupt low.
- R2: The write port decodes these addresses: 0 config (2 bits), 1 enables (bit0 A, bit1 B), 2 modes (bit0 A, bit1 B; 1 means periodic), 3/4 load A/B, 5/6 match A/B, 7/8 prescale A/B (8 bits), 9 mask, 10 clear. Writing a load value also sets that half's count.
- R3: With config 2 (split), an enabled half advances once every (prescale+1) clocks. Its prescale counter stays at zero while the half is disabled. The two halves run independently.
- R4: When a decrement reaches 0, the half's timeout flag is set: flag bit0 for A, bit2 for B. In periodic mode, the next advance reloads the load value, so the period is load+1 advances.
- R5: In one-shot mode, a decrement to zero clears the half's enable bit, and the count then holds. A disabled half never changes its count except by a load write.
- R6: In split mode, a decrement that produces the half's match value sets its match flag: bit1 for A, bit3 for B.
- R7: With config 0 (joined), the 32-bit value {B,A} decrements on every clock while enable bit0 is set. It uses mode bit0 and the 32-bit load {loadB,loadA}, with a borrow carried from A into B. Reaching zero sets bit0, and a result equal to {matchB,matchA} sets bit1. Enable bit1 and the prescalers have no effect.
- R8: With config 1 (joined RTC) and enable bit0 set, the tick pin passes through two synchronising flops. Each rising edge then increments {B,A} by one, wrapping from all ones to 0. An increment producing {matchB,matchA} sets bit1. Without an edge the count holds.
- R9: Flags are sticky; a write to address 10 clears each flag whose data bit is 1 and leaves the others.
- R10: A flag event in the same cycle as a clear of that flag leaves the flag set.
- R11: Status equals flags AND mask, and the interrupt output is the OR of the status bits.
- R12: A register write in the same cycle as counting activity takes precedence for the field it writes. This covers a load write against a decrement, and an enable write against a one-shot stop.
- R13: Config 3 halts all counting, and every count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| rtc_pin | input | 1 | External tick pin for joined RTC counting |
| count_a | output | 16 | Current count of half A (low half when joined) |
| count_b | output | 16 | Current count of half B (high half when joined) |
| running | output | 2 | Enable bits, bit0 A, bit1 B |
| raw_flags | output | 4 | Sticky event flags |
| irq_mask | output | 4 | Interrupt mask |
| irq_status | output | 4 | Masked flags |
| irq | output | 1 | Interrupt line |

## Verification
Two collisions matter most. A flag-clearing write can land in the same clock as the event that sets that flag. A register write can land in the same clock as the counter's own update, either a decrement or a one-shot stop. The bench provokes the first case by writing all-ones to the clear address on every clock while a half with load 1 times out every other clock. It provokes the second case by issuing load and enable writes while a half is decrementing or ending a one-shot run. A behavioural model applies the set-over-clear and write-over-count priorities and is compared against every output on every clock, so any wrong priority shows up in the first cycle it matters.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

    typedef enum logic [1:0] {
        CFG_JOIN  = 2'd0,
        CFG_RTC   = 2'd1,
        CFG_SPLIT = 2'd2,
        CFG_HALT  = 2'd3
    } cfg_e;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_CFG    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_EN     = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_LOAD_A = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_LOAD_B = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_MTCH_A = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_MTCH_B = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_PRE_A  = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_PRE_B  = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_CLEAR  = 4'd10;

    localparam int NFLAGS = 4;
    localparam int FLG_TO_A = 0;
    localparam int FLG_MT_A = 1;
    localparam int FLG_TO_B = 2;
    localparam int FLG_MT_B = 3;

endpackage

// File: rtl/split_timer_prescaler.sv
module split_timer_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    logic [PRE_W-1:0] pc_d, pc_q;

    always_comb begin
        tick = run && (pc_q == limit);
        if (!run) begin
            pc_d = '0;
        end else if (tick) begin
            pc_d = '0;
        end else begin
            pc_d = pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // R3: after a tick with a nonzero divider the next cycle holds no tick
    assert_prescale_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |=> (!tick || limit == '0));

endmodule

// File: rtl/split_timer_edge_sync.sv
module split_timer_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], pin};
        rise = sh_q[1] & ~sh_q[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/split_timer_irq.sv
module split_timer_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] status_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] mask;
    } irq_regs_t;

    irq_regs_t d, q;

    always_comb begin
        d      = q;
        d.raw  = (q.raw & ~clr_i) | set_i;
        if (mask_we_i) begin
            d.mask = mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign raw_o    = q.raw;
    assign mask_o   = q.mask;
    assign status_o = q.raw & q.mask;
    assign irq_o    = |(q.raw & q.mask);

    // R9: without a clear request no flag drops
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

    // R10: an event is never lost to a simultaneous clear
    assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/split_timer.sv
module split_timer
    import split_timer_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int PRE_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rtc_pin,
    output logic [HALF_W-1:0] count_a,
    output logic [HALF_W-1:0] count_b,
    output logic [1:0]        running,
    output logic [NFLAGS-1:0] raw_flags,
    output logic [NFLAGS-1:0] irq_mask,
    output logic [NFLAGS-1:0] irq_status,
    output logic              irq
);

    localparam int FULL_W = 2 * HALF_W;
    localparam int NHALF  = 2;

    typedef struct packed {
        cfg_e                          cfg;
        logic [NHALF-1:0]              en;
        logic [NHALF-1:0]              per;
        logic [NHALF-1:0][HALF_W-1:0]  load;
        logic [NHALF-1:0][HALF_W-1:0]  mtch;
        logic [NHALF-1:0][HALF_W-1:0]  cnt;
        logic [NHALF-1:0][PRE_W-1:0]   pre;
    } regs_t;

    regs_t d, q;

    logic [NHALF-1:0]             tick;
    logic [NHALF-1:0][HALF_W-1:0] dec;
    logic [FULL_W-1:0]            full_q, full_dec, full_inc;
    logic                         rise;
    logic [NFLAGS-1:0]            set_ev;
    logic [NFLAGS-1:0]            clr_req;
    logic                         mask_we;

    // ---------------------------------------------------------------
    // Per-half prescalers, only active in split configuration
    // ---------------------------------------------------------------
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic run_h;
        assign run_h  = (q.cfg == CFG_SPLIT) && q.en[h];
        assign dec[h] = q.cnt[h] - 1'b1;

        split_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_h),
            .limit (q.pre[h]),
            .tick  (tick[h])
        );
    end

    split_timer_edge_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (rtc_pin),
        .rise  (rise)
    );

    assign full_q   = q.cnt;
    assign full_dec = full_q - 1'b1;
    assign full_inc = full_q + 1'b1;

    // ---------------------------------------------------------------
    // Next-state computation: counting first, then register writes
    // ---------------------------------------------------------------
    always_comb begin
        d      = q;
        set_ev = '0;

        unique case (q.cfg)
            CFG_SPLIT: begin
                for (int h = 0; h < NHALF; h++) begin
                    if (q.en[h] && tick[h]) begin
                        if (q.cnt[h] == '0) begin
                            if (q.per[h]) begin
                                d.cnt[h] = q.load[h];
                            end else begin
                                d.en[h] = 1'b0;
                            end
                        end else begin
                            d.cnt[h] = dec[h];
                            if (dec[h] == '0) begin
                                set_ev[2*h] = 1'b1;
                                if (!q.per[h]) begin
                                    d.en[h] = 1'b0;
                                end
                            end
                            if (dec[h] == q.mtch[h]) begin
                                set_ev[2*h+1] = 1'b1;
                            end
                        end
                    end
                end
            end
            CFG_JOIN: begin
                if (q.en[0]) begin
                    if (full_q == '0) begin
                        if (q.per[0]) begin
                            d.cnt = q.load;
                        end else begin
                            d.en[0] = 1'b0;
                        end
                    end else begin
                        d.cnt = full_dec;
                        if (full_dec == '0) begin
                            set_ev[FLG_TO_A] = 1'b1;
                            if (!q.per[0]) begin
                                d.en[0] = 1'b0;
                            end
                        end
                        if (full_dec == q.mtch) begin
                            set_ev[FLG_MT_A] = 1'b1;
                        end
                    end
                end
            end
            CFG_RTC: begin
                if (q.en[0] && rise) begin
                    d.cnt = full_inc;
                    if (full_inc == q.mtch) begin
                        set_ev[FLG_MT_A] = 1'b1;
                    end
                end
            end
            default: begin
            end
        endcase

        if (wr_en) begin
            unique case (wr_addr)
                ADR_CFG:    d.cfg = cfg_e'(wr_data[1:0]);
                ADR_EN:     d.en  = wr_data[1:0];
                ADR_MODE:   d.per = wr_data[1:0];
                ADR_LOAD_A: begin
                    d.load[0] = wr_data[HALF_W-1:0];
                    d.cnt[0]  = wr_data[HALF_W-1:0];
                end
                ADR_LOAD_B: begin
                    d.load[1] = wr_data[HALF_W-1:0];
                    d.cnt[1]  = wr_data[HALF_W-1:0];
                end
                ADR_MTCH_A: d.mtch[0] = wr_data[HALF_W-1:0];
                ADR_MTCH_B: d.mtch[1] = wr_data[HALF_W-1:0];
                ADR_PRE_A:  d.pre[0]  = wr_data[PRE_W-1:0];
                ADR_PRE_B:  d.pre[1]  = wr_data[PRE_W-1:0];
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cfg  <= CFG_JOIN;
            q.load <= '1;
            q.cnt  <= '1;
        end else begin
            q <= d;
        end
    end

    // ---------------------------------------------------------------
    // Interrupt flags
    // ---------------------------------------------------------------
    assign clr_req = (wr_en && wr_addr == ADR_CLEAR) ? wr_data[NFLAGS-1:0] : '0;
    assign mask_we = wr_en && (wr_addr == ADR_MASK);

    split_timer_irq #(.N(NFLAGS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_ev),
        .clr_i     (clr_req),
        .mask_we_i (mask_we),
        .mask_i    (wr_data[NFLAGS-1:0]),
        .raw_o     (raw_flags),
        .mask_o    (irq_mask),
        .status_o  (irq_status),
        .irq_o     (irq)
    );

    assign count_a = q.cnt[0];
    assign count_b = q.cnt[1];
    assign running = q.en;

    // R5: a stopped half in split mode keeps its count unless reloaded
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg == CFG_SPLIT && !q.en[0] && !(wr_en && wr_addr == ADR_LOAD_A))
        |=> $stable(count_a));

    // R7: joined timer ignores enable bit1 when enable bit0 is clear
    assert_join_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg == CFG_JOIN && !q.en[0] && !wr_en)
        |=> ($stable(count_a) && $stable(count_b)));

    // R8: RTC count moves only on a synchronised edge
    assert_rtc_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg == CFG_RTC && !rise && !wr_en)
        |=> ($stable(count_a) && $stable(count_b)));

    // R13: halted configuration freezes both halves
    assert_halt_freeze_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cfg == CFG_HALT && !wr_en)
        |=> ($stable(count_a) && $stable(count_b)));

endmodule

// File: tb/split_timer_bench.sv
module split_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rtc_pin = 1'b0;
    logic [15:0] count_a, count_b;
    logic [1:0]  running;
    logic [3:0]  raw_flags, irq_mask, irq_status;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    split_timer u_split_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rtc_pin    (rtc_pin),
        .count_a    (count_a),
        .count_b    (count_b),
        .running    (running),
        .raw_flags  (raw_flags),
        .irq_mask   (irq_mask),
        .irq_status (irq_status),
        .irq        (irq)
    );

    // ------------------------------------------------------------------
    // Behavioural reference model
    // ------------------------------------------------------------------
    int        m_cfg;
    bit        m_en  [2];
    bit        m_per [2];
    bit [15:0] m_load[2];
    bit [15:0] m_mt  [2];
    bit [15:0] m_cnt [2];
    int        m_pre [2];
    int        m_pc  [2];
    bit        m_tick[2];
    bit        m_s1, m_s2, m_s3, m_rise;
    bit [3:0]  m_raw, m_mask, m_set, m_clr;
    bit [31:0] m_full, m_lim, m_match;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0;
            for (int h = 0; h < 2; h++) begin
                m_en[h] = 0; m_per[h] = 0; m_load[h] = 16'hFFFF; m_mt[h] = 0;
                m_cnt[h] = 16'hFFFF; m_pre[h] = 0; m_pc[h] = 0;
            end
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_raw = 0; m_mask = 0;
        end else begin
            for (int h = 0; h < 2; h++) begin
                bit act;
                act = (m_cfg == 2) && m_en[h];
                m_tick[h] = act && (m_pc[h] == m_pre[h]);
                if (!act || m_tick[h]) m_pc[h] = 0;
                else m_pc[h] = (m_pc[h] + 1) % 256;
            end
            m_rise = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = rtc_pin;
            m_set = 0;
            m_full  = {m_cnt[1], m_cnt[0]};
            m_lim   = {m_load[1], m_load[0]};
            m_match = {m_mt[1], m_mt[0]};
            if (m_cfg == 2) begin
                for (int h = 0; h < 2; h++) begin
                    if (m_en[h] && m_tick[h]) begin
                        if (m_cnt[h] == 0) begin
                            if (m_per[h]) m_cnt[h] = m_load[h];
                            else m_en[h] = 0;
                        end else begin
                            m_cnt[h] = m_cnt[h] - 1;
                            if (m_cnt[h] == 0) begin
                                m_set[2*h] = 1;
                                if (!m_per[h]) m_en[h] = 0;
                            end
                            if (m_cnt[h] == m_mt[h]) m_set[2*h+1] = 1;
                        end
                    end
                end
            end else if (m_cfg == 0) begin
                if (m_en[0]) begin
                    if (m_full == 0) begin
                        if (m_per[0]) m_full = m_lim;
                        else m_en[0] = 0;
                    end else begin
                        m_full = m_full - 1;
                        if (m_full == 0) begin
                            m_set[0] = 1;
                            if (!m_per[0]) m_en[0] = 0;
                        end
                        if (m_full == m_match) m_set[1] = 1;
                    end
                    m_cnt[0] = m_full[15:0]; m_cnt[1] = m_full[31:16];
                end
            end else if (m_cfg == 1) begin
                if (m_en[0] && m_rise) begin
                    m_full = m_full + 1;
                    if (m_full == m_match) m_set[1] = 1;
                    m_cnt[0] = m_full[15:0]; m_cnt[1] = m_full[31:16];
                end
            end
            m_clr = 0;
            if (wr_en) begin
                case (wr_addr)
                    4'd0:  m_cfg = wr_data[1:0];
                    4'd1:  begin m_en[0] = wr_data[0]; m_en[1] = wr_data[1]; end
                    4'd2:  begin m_per[0] = wr_data[0]; m_per[1] = wr_data[1]; end
                    4'd3:  begin m_load[0] = wr_data; m_cnt[0] = wr_data; end
                    4'd4:  begin m_load[1] = wr_data; m_cnt[1] = wr_data; end
                    4'd5:  m_mt[0] = wr_data;
                    4'd6:  m_mt[1] = wr_data;
                    4'd7:  m_pre[0] = wr_data[7:0];
                    4'd8:  m_pre[1] = wr_data[7:0];
                    4'd9:  m_mask = wr_data[3:0];
                    4'd10: m_clr = wr_data[3:0];
                    default: ;
                endcase
            end
            m_raw = (m_raw & ~m_clr) | m_set;
        end
    end

    // Compare every output once per clock, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            bit [3:0] st;
            st = m_raw & m_mask;
            checks++;
            if (count_a !== m_cnt[0] || count_b !== m_cnt[1] ||
                running !== {m_en[1], m_en[0]} || raw_flags !== m_raw ||
                irq_mask !== m_mask || irq_status !== st || irq !== (|st)) begin
                errors++;
                $display("FAIL %s t=%0t actual a=%h b=%h run=%b raw=%b mask=%b st=%b irq=%b expected a=%h b=%h run=%b raw=%b mask=%b st=%b irq=%b",
                         phase, $time, count_a, count_b, running, raw_flags, irq_mask,
                         irq_status, irq, m_cnt[0], m_cnt[1], {m_en[1], m_en[0]},
                         m_raw, m_mask, st, |st);
            end
        end
    end

    // ------------------------------------------------------------------
    // Stimulus helpers (called at a falling edge, return at one)
    // ------------------------------------------------------------------
    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        rtc_pin = 1'b1; idle(hi);
        rtc_pin = 1'b0; idle(lo);
    endtask

    task automatic explicit_check(input string tag, input logic ok, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual a=%h b=%h run=%b raw=%b", tag, what,
                     count_a, count_b, running, raw_flags);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R1";
        explicit_check("R1", count_a == 16'hFFFF && count_b == 16'hFFFF && raw_flags == 0 && !irq,
                       "reset state expected counts FFFF, flags 0");
        idle(4);

        phase = "R13";
        wr(4'd0, 16'd3); wr(4'd1, 16'd3); wr(4'd2, 16'd3);
        idle(10);
        explicit_check("R13", count_a == 16'hFFFF && count_b == 16'hFFFF, "halt expected counts FFFF");

        phase = "R2";
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd2);
        wr(4'd3, 16'd5); wr(4'd4, 16'd9);
        explicit_check("R2", count_a == 16'd5 && count_b == 16'd9, "load expected a=5 b=9");
        wr(4'd5, 16'hFFFF); wr(4'd6, 16'hFFFF);

        phase = "R3";
        wr(4'd7, 16'd2); wr(4'd8, 16'd0);
        wr(4'd2, 16'd3);
        wr(4'd1, 16'd3);
        idle(40);

        phase = "R4";
        wr(4'd10, 16'hF);
        wr(4'd3, 16'd3); wr(4'd7, 16'd1);
        idle(30);
        explicit_check("R4", raw_flags[0] == 1'b1, "timeout A expected flag bit0 set");

        phase = "R5";
        wr(4'd1, 16'd0); wr(4'd10, 16'hF);
        wr(4'd2, 16'd0);
        wr(4'd3, 16'd3); wr(4'd7, 16'd0);
        wr(4'd4, 16'd6); wr(4'd8, 16'd1);
        wr(4'd1, 16'd3);
        idle(25);
        explicit_check("R5", running == 2'b00 && count_a == 0 && count_b == 0,
                       "one-shot expected both stopped at zero");

        phase = "R6";
        wr(4'd10, 16'hF);
        wr(4'd5, 16'd2); wr(4'd6, 16'd4);
        wr(4'd3, 16'd6); wr(4'd4, 16'd7);
        wr(4'd1, 16'd3);
        idle(20);
        explicit_check("R6", raw_flags[1] && raw_flags[3], "match expected bits 1 and 3");

        phase = "R12";
        wr(4'd2, 16'd1); wr(4'd3, 16'd8); wr(4'd1, 16'd1);
        idle(3);
        wr(4'd3, 16'd20);
        idle(2);
        wr(4'd3, 16'd2); wr(4'd2, 16'd0);
        idle(1);
        wr(4'd1, 16'd1);
        idle(6);

        phase = "R7";
        wr(4'd1, 16'd0); wr(4'd10, 16'hF);
        wr(4'd0, 16'd0);
        wr(4'd3, 16'd1); wr(4'd4, 16'd1);
        wr(4'd5, 16'hFFFE); wr(4'd6, 16'd0);
        wr(4'd1, 16'd2);
        idle(5);
        explicit_check("R7", count_a == 16'd1 && count_b == 16'd1, "enable bit1 expected ignored");
        wr(4'd2, 16'd1);
        wr(4'd1, 16'd1);
        idle(10);
        wr(4'd3, 16'd4); wr(4'd4, 16'd0);
        idle(15);

        phase = "R8";
        wr(4'd1, 16'd0); wr(4'd10, 16'hF);
        wr(4'd0, 16'd1);
        wr(4'd3, 16'hFFFE); wr(4'd4, 16'hFFFF);
        wr(4'd5, 16'd1); wr(4'd6, 16'd0);
        wr(4'd1, 16'd1);
        pulse(1, 3); pulse(2, 2); pulse(3, 1); pulse(1, 5); pulse(4, 4);
        idle(5);
        explicit_check("R8", count_a == 16'd3 && count_b == 16'd0 && raw_flags[1],
                       "rtc expected count 3 after five edges with match bit1");

        phase = "R9";
        wr(4'd1, 16'd0);
        wr(4'd10, 16'h0);
        idle(2);
        wr(4'd10, 16'h2);
        idle(2);
        explicit_check("R9", raw_flags[1] == 1'b0, "clear expected bit1 low");

        phase = "R10";
        wr(4'd0, 16'd2); wr(4'd7, 16'd0);
        wr(4'd3, 16'd1); wr(4'd2, 16'd1);
        wr(4'd1, 16'd1);
        for (int i = 0; i < 12; i++) wr(4'd10, 16'hF);
        idle(2);

        phase = "R11";
        wr(4'd9, 16'h1); idle(4);
        wr(4'd9, 16'h4); idle(4);
        wr(4'd9, 16'hF); idle(4);
        wr(4'd1, 16'd0); wr(4'd10, 16'hF); idle(2);
        explicit_check("R11", irq == 1'b0, "cleared flags expected irq low");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog %s actual cycles=%0d expected under %0d", phase, cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule